// File: doc/BRIEF.md
# Two-Write Two-Read Replicated Memory

This block is a word-addressed memory that accepts two independent writes and two independent reads in every clock cycle, all on a single clock. It needs no faster internal clock. It is built from simple memories that have one write port and one read port. Each pairing of a write port with a read port gets its own bank, so there are four banks in total. Write port A updates the two banks it owns, and write port B updates its own two. Each read port therefore sees two candidate words for any address.

A read port must know which candidate is current. One bit table per writer records this, one bit per address. When writer A stores a word, it copies writer B's bit for that address into its own table. When writer B stores a word, it writes the inverse of writer A's bit into its own table. A reader fetches both candidate words together with both table bits. If the two bits agree, it returns the A-side word. If they differ, it returns the B-side word.

Read data appears one cycle after the address is presented. The two write ports must never target the same address in the same cycle.

Top module: `twin_write_ram`

## Requirements
- R1: A word written through port A (wa_en=1) at address x is returned by both read ports for reads of x issued in any later cycle. Read data is valid on the clock edge after the one that samples the read address.
- R2: A word written through port B (wb_en=1) at address x is returned by both read ports for reads of x issued in any later cycle.
- R3: A write through A and a write through B in the same cycle, to different addresses, are both stored.
- R4: When one address is written several times, in separate cycles and by either port in any order, later reads return the most recent word.
- R5: Read port C (rc_addr/rc_data) and read port D (rd_addr/rd_data) take independent addresses in the same cycle.
- R6: A read issued in the same cycle as a write to the same address returns the word that was stored before that write.
- R7: Synchronous active-high reset clears every live-value bit. After reset, a read returns the word last written by port A to that address, even if port B wrote it more recently.
- R8: A port whose enable is 0 changes no stored word, whatever its address and data inputs hold.
- R9: The two write ports must never be enabled on the same address in the same cycle. This is a usage rule placed on the surrounding logic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all ports |
| rst | input | 1 | Synchronous active-high reset of the live-value bits |
| wa_en | input | 1 | Write enable, port A |
| wa_addr | input | AW | Write address, port A |
| wa_data | input | DW | Write data, port A |
| wb_en | input | 1 | Write enable, port B |
| wb_addr | input | AW | Write address, port B |
| wb_data | input | DW | Write data, port B |
| rc_addr | input | AW | Read address, port C |
| rc_data | output | DW | Read data, port C, one cycle after the address |
| rd_addr | input | AW | Read address, port D |
| rd_data | output | DW | Read data, port D, one cycle after the address |

## Verification
A read and a write to the same address can fall in the same cycle. The bench provokes this by issuing a read of an address in the very cycle that port B, or port A, overwrites it. The read must return the older word, and a read in the following cycle must return the new one. The second collision is between the two write ports at different addresses in one cycle. Both words are checked afterwards, and a disabled port whose address matches a live word is checked to leave that word unchanged.

// File: rtl/twin_ram_pkg.sv
package twin_ram_pkg;

  localparam int unsigned NUM_RD = 2;

  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_e;

  // Matching live bits mean writer A was last; differing bits mean writer B.
  function automatic side_e pick_side(input logic a_bit, input logic b_bit);
    return (a_bit == b_bit) ? SIDE_A : SIDE_B;
  endfunction

endpackage

// File: rtl/twr_bank.sv
module twr_bank #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Read-before-write: a same-cycle read sees the previous word.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/twr_live_table.sv
module twr_live_table #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned NRD   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic                    wbit,
  input  logic [AW-1:0]           xaddr,
  output logic                    xbit,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0]          rbit,
  output logic [DEPTH-1:0]        bits_o
);

  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst)     bits_q <= '0;
    else if (we) bits_q[waddr] <= wbit;
  end

  // Unregistered lookup used by the other writer.
  assign xbit   = bits_q[xaddr];
  assign bits_o = bits_q;

  // One registered lookup per reader, aligned with the bank outputs.
  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst) bit_q <= 1'b0;
      else     bit_q <= bits_q[raddr[r]];
    end
    assign rbit[r] = bit_q;
  end

  p_bit_store_r4: assert property (@(posedge clk) disable iff (rst)
    we |=> (bits_q[$past(waddr)] == $past(wbit)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(bits_q));

endmodule

// File: rtl/twr_read_port.sv
module twr_read_port
  import twin_ram_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic [1:0]             we,
  input  logic [1:0][AW-1:0]     waddr,
  input  logic [1:0][DW-1:0]     wdata,
  input  logic [AW-1:0]          raddr,
  input  logic                   sem_a,
  input  logic                   sem_b,
  output logic [DW-1:0]          rdata
);

  logic [1:0][DW-1:0] bank_q;
  side_e              sel;

  // Index 0 is the bank owned by writer A, index 1 the one owned by writer B.
  for (genvar s = 0; s < 2; s++) begin : g_side
    twr_bank #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk   (clk),
      .we    (we[s]),
      .waddr (waddr[s]),
      .wdata (wdata[s]),
      .raddr (raddr),
      .rdata (bank_q[s])
    );
  end

  assign sel   = pick_side(sem_a, sem_b);
  assign rdata = (sel == SIDE_B) ? bank_q[1] : bank_q[0];

endmodule

// File: rtl/twin_write_ram.sv
module twin_write_ram
  import twin_ram_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wa_en,
  input  logic [$clog2(DEPTH)-1:0] wa_addr,
  input  logic [DW-1:0]            wa_data,
  input  logic                     wb_en,
  input  logic [$clog2(DEPTH)-1:0] wb_addr,
  input  logic [DW-1:0]            wb_data,
  input  logic [$clog2(DEPTH)-1:0] rc_addr,
  output logic [DW-1:0]            rc_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DW-1:0]            rd_data
);

  localparam int unsigned AW = $clog2(DEPTH);

  logic [NUM_RD-1:0][AW-1:0] rd_addr_v;
  logic [NUM_RD-1:0]         sa_r, sb_r;
  logic [NUM_RD-1:0][DW-1:0] rdata_v;
  logic [DEPTH-1:0]          sa_vec, sb_vec;
  logic                      a_sees_b, b_sees_a;
  logic [1:0]                we_v;
  logic [1:0][AW-1:0]        waddr_v;
  logic [1:0][DW-1:0]        wdata_v;

  assign rd_addr_v = {rd_addr, rc_addr};
  assign we_v      = {wb_en, wa_en};
  assign waddr_v   = {wb_addr, wa_addr};
  assign wdata_v   = {wb_data, wa_data};

  // Writer A copies B's bit; writer B stores the inverse of A's bit.
  twr_live_table #(.DEPTH(DEPTH), .AW(AW), .NRD(NUM_RD)) u_live_a (
    .clk   (clk),
    .rst   (rst),
    .we    (wa_en),
    .waddr (wa_addr),
    .wbit  (a_sees_b),
    .xaddr (wb_addr),
    .xbit  (b_sees_a),
    .raddr (rd_addr_v),
    .rbit  (sa_r),
    .bits_o(sa_vec)
  );

  twr_live_table #(.DEPTH(DEPTH), .AW(AW), .NRD(NUM_RD)) u_live_b (
    .clk   (clk),
    .rst   (rst),
    .we    (wb_en),
    .waddr (wb_addr),
    .wbit  (~b_sees_a),
    .xaddr (wa_addr),
    .xbit  (a_sees_b),
    .raddr (rd_addr_v),
    .rbit  (sb_r),
    .bits_o(sb_vec)
  );

  for (genvar r = 0; r < NUM_RD; r++) begin : g_port
    twr_read_port #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_port (
      .clk   (clk),
      .we    (we_v),
      .waddr (waddr_v),
      .wdata (wdata_v),
      .raddr (rd_addr_v[r]),
      .sem_a (sa_r[r]),
      .sem_b (sb_r[r]),
      .rdata (rdata_v[r])
    );
  end

  assign rc_data = rdata_v[0];
  assign rd_data = rdata_v[1];

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  p_no_same_addr_r9: assert property (@(posedge clk) disable iff (rst)
    !(wa_en && wb_en && (wa_addr == wb_addr)));

  p_a_latest_r4: assert property (@(posedge clk) disable iff (rst)
    (wa_en && !(wb_en && (wb_addr == wa_addr)))
      |=> (sa_vec[$past(wa_addr)] == sb_vec[$past(wa_addr)]));

  p_b_latest_r4: assert property (@(posedge clk) disable iff (rst)
    (wb_en && !(wa_en && (wa_addr == wb_addr)))
      |=> (sa_vec[$past(wb_addr)] != sb_vec[$past(wb_addr)]));

  p_reset_clear_r7: assert property (@(posedge clk)
    (rst_d && !rst) |-> ((sa_vec == '0) && (sb_vec == '0)));

endmodule

// File: tb/twin_write_ram_test.sv
module twin_write_ram_test;

  localparam int DW = 16;
  localparam int DEPTH = 64;
  localparam int AW = 6;

  typedef struct packed {
    logic          wa_en;
    logic [AW-1:0] wa_a;
    logic [DW-1:0] wa_d;
    logic          wb_en;
    logic [AW-1:0] wb_a;
    logic [DW-1:0] wb_d;
    logic [AW-1:0] rc_a;
    logic [AW-1:0] rd_a;
    logic          chk;
    logic [DW-1:0] ec;
    logic [DW-1:0] ed;
  } vec_t;

  localparam int NV = 11;
  // Expected values are for reads issued in the same vector.
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'd1, 16'h1111, 1'b1, 6'd2, 16'h2222, 6'd0, 6'd0, 1'b0, 16'h0000, 16'h0000},
    '{1'b0, 6'd0, 16'h0000, 1'b0, 6'd0, 16'h0000, 6'd1, 6'd2, 1'b1, 16'h1111, 16'h2222},
    '{1'b1, 6'd3, 16'h3333, 1'b1, 6'd1, 16'hB001, 6'd2, 6'd1, 1'b1, 16'h2222, 16'h1111},
    '{1'b0, 6'd0, 16'h0000, 1'b0, 6'd0, 16'h0000, 6'd1, 6'd3, 1'b1, 16'hB001, 16'h3333},
    '{1'b1, 6'd1, 16'hA002, 1'b0, 6'd2, 16'hDEAD, 6'd1, 6'd1, 1'b1, 16'hB001, 16'hB001},
    '{1'b0, 6'd0, 16'h0000, 1'b0, 6'd0, 16'h0000, 6'd1, 6'd2, 1'b1, 16'hA002, 16'h2222},
    '{1'b0, 6'd0, 16'h0000, 1'b1, 6'd1, 16'hB003, 6'd1, 6'd3, 1'b1, 16'hA002, 16'h3333},
    '{1'b0, 6'd0, 16'h0000, 1'b1, 6'd1, 16'hB004, 6'd1, 6'd1, 1'b1, 16'hB003, 16'hB003},
    '{1'b0, 6'd0, 16'h0000, 1'b0, 6'd0, 16'h0000, 6'd1, 6'd1, 1'b1, 16'hB004, 16'hB004},
    '{1'b1, 6'd1, 16'hA005, 1'b1, 6'd2, 16'h2020, 6'd2, 6'd1, 1'b1, 16'h2222, 16'hB004},
    '{1'b0, 6'd0, 16'h0000, 1'b0, 6'd0, 16'h0000, 6'd1, 6'd2, 1'b1, 16'hA005, 16'h2020}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wa_en = 1'b0, wb_en = 1'b0;
  logic [AW-1:0] wa_addr = '0, wb_addr = '0, rc_addr = '0, rd_addr = '0;
  logic [DW-1:0] wa_data = '0, wb_data = '0;
  logic [DW-1:0] rc_data, rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  twin_write_ram #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .rc_addr(rc_addr), .rc_data(rc_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a negative edge: drive, cross one rising edge, return at the next negative edge.
  task automatic apply(input vec_t v);
    wa_en = v.wa_en; wa_addr = v.wa_a; wa_data = v.wa_d;
    wb_en = v.wb_en; wb_addr = v.wb_a; wb_data = v.wb_d;
    rc_addr = v.rc_a; rd_addr = v.rd_a;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic vec_t mk(input logic ae, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                              input logic be, input logic [AW-1:0] ba, input logic [DW-1:0] bd,
                              input logic [AW-1:0] ca, input logic [AW-1:0] da);
    vec_t v;
    v = '0;
    v.wa_en = ae; v.wa_a = aa; v.wa_d = ad;
    v.wb_en = be; v.wb_a = ba; v.wb_d = bd;
    v.rc_a = ca; v.rd_a = da;
    return v;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // Table walk. It covers R1, R2, R3, R4, R5, R6 and R8.
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      if (VECS[i].chk) begin
        check($sformatf("R1/R2/R3/R5 vec %0d port C", i), rc_data, VECS[i].ec);
        check($sformatf("R4/R6/R8 vec %0d port D", i), rd_data, VECS[i].ed);
      end
    end

    // R6: port C reads address 9 while port A writes it, then reads it again.
    apply(mk(1'b1, 6'd9, 16'h0909, 1'b0, 6'd0, 16'h0, 6'd0, 6'd0));
    apply(mk(1'b1, 6'd9, 16'h9999, 1'b0, 6'd0, 16'h0, 6'd9, 6'd9));
    check("R6 same-cycle read returns old word", rc_data, 16'h0909);
    apply(mk(1'b0, 6'd0, 16'h0, 1'b0, 6'd0, 16'h0, 6'd9, 6'd9));
    check("R6 next-cycle read returns new word", rd_data, 16'h9999);

    // R7: A writes 5, then B overwrites it. After reset the A-side word must return.
    apply(mk(1'b1, 6'd5, 16'h0A0A, 1'b0, 6'd0, 16'h0, 6'd0, 6'd0));
    apply(mk(1'b0, 6'd0, 16'h0, 1'b1, 6'd5, 16'h0B0B, 6'd0, 6'd0));
    apply(mk(1'b0, 6'd0, 16'h0, 1'b0, 6'd0, 16'h0, 6'd5, 6'd5));
    check("R4 B word before reset", rc_data, 16'h0B0B);
    rst = 1'b1;
    apply(mk(1'b0, 6'd0, 16'h0, 1'b0, 6'd0, 16'h0, 6'd0, 6'd0));
    rst = 1'b0;
    apply(mk(1'b0, 6'd0, 16'h0, 1'b0, 6'd0, 16'h0, 6'd5, 6'd1));
    check("R7 reset selects A side, port C", rc_data, 16'h0A0A);
    check("R7 reset selects A side, port D", rd_data, 16'hA005);

    // R2 after reset: a B write must still win.
    apply(mk(1'b0, 6'd0, 16'h0, 1'b1, 6'd5, 16'h5B5B, 6'd0, 6'd0));
    apply(mk(1'b0, 6'd0, 16'h0, 1'b0, 6'd0, 16'h0, 6'd5, 6'd5));
    check("R2 B write after reset, port C", rc_data, 16'h5B5B);
    check("R2 B write after reset, port D", rd_data, 16'h5B5B);

    // R8: both ports disabled with live addresses; nothing may change.
    apply(mk(1'b0, 6'd5, 16'hFFFF, 1'b0, 6'd9, 16'hEEEE, 6'd0, 6'd0));
    apply(mk(1'b0, 6'd0, 16'h0, 1'b0, 6'd0, 16'h0, 6'd5, 6'd9));
    check("R8 disabled A leaves word", rc_data, 16'h5B5B);
    check("R8 disabled B leaves word", rd_data, 16'h9999);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end

endmodule